// File: doc/BRIEF.md
# Start-of-Frame Loss Watchdog

This block watches a device-side serial bus link for start-of-frame tokens that fail to arrive while the link is up. A free-running microsecond tick drives a frame timer. If no start-of-frame is seen before the timer reaches its limit, the block emits a one-cycle missed-frame strobe and starts timing the next frame window from zero.

A second counter records how many frame windows in a row have gone by without a start-of-frame. When that count reaches a set number, a host-lost flag rises and stays high. It falls only when one of three things happens: a start-of-frame arrives, the link drops, or a bus reset is signalled. Link-management logic uses the strobe to keep its frame count in step and uses the flag to decide that the host has gone away.

Top module: `sof_watchdog`

## Requirements
- R1: After the asynchronous active-low reset, `frame_miss_o` and `host_gone_o` are both 0.
- R2: While the link is up and no clear condition is present, the frame timer advances by one only in cycles where `us_tick_i` is 1. Cycles without a tick leave it unchanged.
- R3: `frame_miss_o` is high in the cycle after the TICK_LIMIT-th counted tick since the last clear. It lasts exactly one cycle. The timer then restarts from zero, and a tick in the strobe cycle is not counted.
- R4: A cycle with `sof_seen_i` high clears the frame timer and the consecutive-miss count, so both outputs are 0 in the following cycle. A tick in that same cycle is not counted.
- R5: While `link_up_i` is 0, the timer and the miss count are held at zero, and no strobe or host-lost indication appears, whatever ticks arrive.
- R6: A cycle with `link_rst_i` high clears the timer and the miss count, as R4 does.
- R7: `host_gone_o` rises in the cycle after the MISS_LIMIT-th consecutive missed-frame strobe. A start-of-frame between two misses restarts the run.
- R8: Once `host_gone_o` is high, it stays high through further missed-frame strobes until a clear condition from R4, R5 or R6 occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| us_tick_i | input | 1 | One-cycle pulse each microsecond |
| sof_seen_i | input | 1 | One-cycle pulse on a received start-of-frame |
| link_up_i | input | 1 | Level, high while the link is active |
| link_rst_i | input | 1 | Level, high while a bus reset is present |
| frame_miss_o | output | 1 | One-cycle strobe on a missed start-of-frame |
| host_gone_o | output | 1 | Sticky flag after consecutive misses |

## Verification
The bench builds the block with TICK_LIMIT=8 and MISS_LIMIT=3. A full frame window therefore lasts nine cycles when a tick arrives every cycle. A run of misses long enough to set the host-lost flag fits in a few dozen cycles. These small values let the bench walk an exact cycle-by-cycle timeline that covers the strobe timing, the restart after each miss, the frozen count once the flag is set, and interrupted miss runs. Stretches without ticks check that the timer holds while the link is up.

// File: rtl/sof_watchdog.sv
module sof_watchdog #(
  parameter int TICK_LIMIT = 1024,
  parameter int MISS_LIMIT = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic us_tick_i,
  input  logic sof_seen_i,
  input  logic link_up_i,
  input  logic link_rst_i,
  output logic frame_miss_o,
  output logic host_gone_o
);

  localparam int TW = $clog2(TICK_LIMIT + 1);
  localparam int MW = $clog2(MISS_LIMIT + 1);
  localparam logic [TW-1:0] TMAX = TW'(TICK_LIMIT);
  localparam logic [MW-1:0] MMAX = MW'(MISS_LIMIT);

  logic [TW-1:0] tmr_q;
  logic [MW-1:0] miss_q;
  logic          wipe;

  assign wipe         = sof_seen_i || !link_up_i || link_rst_i;
  assign frame_miss_o = (tmr_q == TMAX);
  assign host_gone_o  = (miss_q == MMAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   tmr_q <= '0;
    else if (wipe || frame_miss_o) tmr_q <= '0;
    else if (us_tick_i)            tmr_q <= tmr_q + TW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           miss_q <= '0;
    else if (wipe)                         miss_q <= '0;
    else if (frame_miss_o && !host_gone_o) miss_q <= miss_q + MW'(1);
  end

  always_ff @(posedge clk_i) begin
    if (rst_ni) begin
      assert (tmr_q <= TMAX && miss_q <= MMAX)
        else $error("counter out of range");
    end
  end

  assert_no_tick_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!us_tick_i && !wipe && !frame_miss_o) |=> $stable(tmr_q));

  assert_single_strobe_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_miss_o |=> !frame_miss_o);

  assert_sof_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_seen_i |=> (!frame_miss_o && !host_gone_o));

  assert_link_down_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !link_up_i |=> (!frame_miss_o && !host_gone_o));

  assert_bus_rst_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_rst_i |=> (!frame_miss_o && !host_gone_o));

  assert_lost_after_miss_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(host_gone_o) |-> $past(frame_miss_o));

  assert_lost_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_gone_o && !wipe) |=> host_gone_o);

endmodule

// File: tb/sim_sof_watchdog.sv
module sim_sof_watchdog;
  localparam int TL = 8;
  localparam int ML = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, sof = 1'b0, link = 1'b0, brst = 1'b0;
  logic miss, gone;
  int   errs = 0, checks = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  sof_watchdog #(.TICK_LIMIT(TL), .MISS_LIMIT(ML)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .us_tick_i(tick), .sof_seen_i(sof),
    .link_up_i(link), .link_rst_i(brst), .frame_miss_o(miss), .host_gone_o(gone));

  // cycles to advance (tick every cycle, link up), then expected miss, gone
  localparam int NV = 8;
  localparam int VEC [NV][3] = '{
    '{7, 0, 0}, '{1, 1, 0}, '{1, 0, 0}, '{8, 1, 0},
    '{9, 1, 0}, '{1, 0, 1}, '{8, 1, 1}, '{1, 0, 1}};

  task automatic cyc(input logic t, input logic s, input logic l, input logic r);
    @(negedge clk);
    tick = t; sof = s; link = l; brst = r;
    @(posedge clk);
    #2;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic chk(input string req, input logic em, input logic eg);
    checks++;
    if (miss !== em || gone !== eg) begin
      errs++;
      $display("FAIL %s: miss=%b gone=%b expected miss=%b gone=%b", req, miss, gone, em, eg);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    errs++; checks++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    #35;
    chk("R1 reset", 1'b0, 1'b0);
    rst_n = 1'b1;
    cyc(1'b0, 1'b0, 1'b1, 1'b0);
    chk("R1 after release", 1'b0, 1'b0);

    // R3 R7 R8: continuous ticks, timeline walk
    for (int v = 0; v < NV; v++) begin
      run(VEC[v][0]);
      chk($sformatf("R3/R7/R8 vec%0d", v), 1'(VEC[v][1]), 1'(VEC[v][2]));
    end

    // R4: sof clears host lost
    cyc(1'b1, 1'b1, 1'b1, 1'b0);
    chk("R4 sof clears", 1'b0, 1'b0);
    run(5);
    cyc(1'b1, 1'b1, 1'b1, 1'b0);
    run(7);
    chk("R4 timer restarted by sof", 1'b0, 1'b0);
    run(1);
    chk("R4 miss after full window", 1'b1, 1'b0);

    // R2: ticks gate the timer
    run(1);
    run(3);
    for (int i = 0; i < 50; i++) cyc(1'b0, 1'b0, 1'b1, 1'b0);
    chk("R2 idle no strobe", 1'b0, 1'b0);
    run(4);
    chk("R2 no early miss", 1'b0, 1'b0);
    run(1);
    chk("R2 miss at 8 ticks", 1'b1, 1'b0);

    // R5: link down holds everything
    run(1);
    for (int i = 0; i < 30; i++) cyc(1'b1, 1'b0, 1'b0, 1'b0);
    chk("R5 link down", 1'b0, 1'b0);
    run(8);
    chk("R5 fresh window", 1'b1, 1'b0);

    // R7: interrupted run does not reach the limit
    run(1); run(8);
    chk("R7 second miss", 1'b1, 1'b0);
    run(1);
    cyc(1'b1, 1'b1, 1'b1, 1'b0);
    run(8); run(1); run(8); run(1);
    chk("R7 run restarted by sof", 1'b0, 1'b0);
    run(8); run(1);
    chk("R7 third in run", 1'b0, 1'b1);

    // R6: bus reset clears host lost
    cyc(1'b1, 1'b0, 1'b1, 1'b1);
    chk("R6 bus reset clears", 1'b0, 1'b0);
    for (int i = 0; i < 20; i++) cyc(1'b1, 1'b0, 1'b1, 1'b1);
    chk("R6 held in reset", 1'b0, 1'b0);

    // R8: link down clears sticky flag
    run(27);
    chk("R8 lost again", 1'b0, 1'b1);
    cyc(1'b1, 1'b0, 1'b0, 1'b0);
    chk("R8 link down clears", 1'b0, 1'b0);

    finish_run();
  end
endmodule